// File: doc/BRIEF.md
# Per-Channel Differential Line Router

This block sits between one UART channel and its differential line transceivers. An 8-bit routing value picks the source of every line-side control. The driver enable can be held on, follow DTR, follow RTS, or key itself from transmitter activity. The auxiliary output pair can carry RTS or the transmit clock. The receive clock and CTS can come from the transmit clock, the auxiliary input or RTS. The receiver enable can be held on or made the inverse of the driver enable, which gives half-duplex operation.

Bit 4 of the routing value is a loopback override. When it is set, the auxiliary input is echoed to the auxiliary output, the transmit clock feeds the receive clock, and RTS feeds CTS, whatever bits 2 and 3 say. The routing value is captured on each rising clock edge. The driver enable in the DTR and RTS modes is registered, so the transceiver enable never glitches. In auto-toggle mode the enable rises together with the transmitter-busy input. It then holds for `BIT_CYCLES` clocks after busy falls, so the final stop bit is fully driven onto the line.

Top module: `line_route_chan`

## Requirements
- R1: While reset is asserted and right after it, `route_q` is 0x00 and both `txen` and `rxen` are 1.
- R2: A new `route_cfg` has no effect on any output until the next rising edge of `clk`, and takes effect right after that edge.
- R3: `route_q[1:0]` selects `txen`: 00 gives 1, 01 gives DTR sampled at the previous rising edge, and 10 gives RTS sampled at the previous rising edge.
- R4: With `route_q[1:0]` = 11, `txen` is 1 in every cycle in which `tx_busy` is 1, combinationally. It stays 1 for exactly `BIT_CYCLES` clock cycles after `tx_busy` falls, then drops to 0.
- R5: With `route_q[4]` = 0, `route_q[2]` = 0 drives `aux_out` from RTS, and 1 drives it from `tx_clk`.
- R6: With `route_q[4]` = 0, `route_q[3]` = 0 gives `rclk` = `tx_clk` and `cts` = `aux_in`, and 1 gives `rclk` = `aux_in` and `cts` = RTS.
- R7: With `route_q[4]` = 1, `aux_out` = `aux_in`, `rclk` = `tx_clk` and `cts` = RTS, regardless of bits 2 and 3.
- R8: `route_q[5]` = 0 holds `rxen` at 1, and 1 makes `rxen` the inverse of `txen`.
- R9: Bits 7:6 of `route_cfg` have no effect on any output, and `route_q[7:6]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| route_cfg | input | 8 | Routing control value |
| rts | input | 1 | UART RTS output |
| dtr | input | 1 | UART DTR output |
| tx_clk | input | 1 | Transmit clock |
| aux_in | input | 1 | Auxiliary line input |
| tx_busy | input | 1 | Transmitter shifting a character |
| txen | output | 1 | Line driver enable |
| rxen | output | 1 | Line receiver enable |
| aux_out | output | 1 | Auxiliary line output |
| rclk | output | 1 | Receive clock to the UART |
| cts | output | 1 | CTS to the UART |
| route_q | output | 8 | Routing value in force, bits 7:6 zero |

## Verification
The bench sweeps all 64 values of bits 5:0 against all 16 combinations of RTS, DTR, transmit clock and auxiliary input. That catches a design that lets bits 2 or 3 leak through the loopback override, or that swaps the receive clock and CTS sources. Directed cases probe timing. A design that decodes `route_cfg` combinationally would change `aux_out` before the edge. An unregistered enable would follow DTR in the same cycle. An auto-toggle hangover that is off by one would cut the stop bit short or hold the driver a cycle too long. A row with only bits 7:6 set exposes a design that lets those bits reach an output or the readback.

// File: rtl/line_route_chan.sv
module line_route_chan #(
  parameter int BIT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] route_cfg,
  input  logic       rts,
  input  logic       dtr,
  input  logic       tx_clk,
  input  logic       aux_in,
  input  logic       tx_busy,
  output logic       txen,
  output logic       rxen,
  output logic       aux_out,
  output logic       rclk,
  output logic       cts,
  output logic [7:0] route_q
);
  localparam int CNT_W = $clog2(BIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] HANG_LOAD = CNT_W'(BIT_CYCLES);

  logic [5:0]       cfg_q;
  logic             txen_q;
  logic [CNT_W-1:0] hang_q;
  logic             auto_mode;
  logic             loop_on;
  logic             unused_hi;

  assign unused_hi = ^route_cfg[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      txen_q <= 1'b1;
    end else begin
      cfg_q <= route_cfg[5:0];
      unique case (route_cfg[1:0])
        2'b00:   txen_q <= 1'b1;
        2'b01:   txen_q <= dtr;
        2'b10:   txen_q <= rts;
        default: txen_q <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hang_q <= '0;
    else if (tx_busy)       hang_q <= HANG_LOAD;
    else if (hang_q != '0)  hang_q <= hang_q - 1'b1;
  end

  assign auto_mode = (cfg_q[1:0] == 2'b11);
  assign loop_on   = cfg_q[4];

  assign txen    = auto_mode ? (tx_busy | (hang_q != '0)) : txen_q;
  assign rxen    = cfg_q[5] ? ~txen : 1'b1;
  assign aux_out = loop_on ? aux_in : (cfg_q[2] ? tx_clk : rts);
  assign rclk    = (cfg_q[3] && !loop_on) ? aux_in : tx_clk;
  assign cts     = (cfg_q[3] || loop_on) ? rts : aux_in;
  assign route_q = {2'b00, cfg_q};
endmodule

// File: rtl/line_route_chan_chk.sv
module line_route_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] route_cfg,
  input logic       rts,
  input logic       dtr,
  input logic       tx_clk,
  input logic       aux_in,
  input logic       tx_busy,
  input logic       txen,
  input logic       rxen,
  input logic       aux_out,
  input logic       rclk,
  input logic       cts,
  input logic [7:0] route_q
);
  a_r3_fixed_on: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[1:0] == 2'b00) |-> txen);

  a_r3_dtr_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[1:0] == 2'b01) |-> (txen == $past(dtr)));

  a_r4_busy_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ((route_q[1:0] == 2'b11) && tx_busy) |-> txen);

  a_r4_hang_start: assert property (@(posedge clk) disable iff (!rst_n)
    ((route_q[1:0] == 2'b11) && $fell(tx_busy)) |-> txen);

  a_r7_loopback: assert property (@(posedge clk) disable iff (!rst_n)
    route_q[4] |-> (aux_out == aux_in && rclk == tx_clk && cts == rts));

  a_r8_rx_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    route_q[5] |-> (rxen != txen));

  a_r9_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (route_cfg[7:6] != 2'b00) |=> (route_q[7:6] == 2'b00));
endmodule

bind line_route_chan line_route_chan_chk chk_i (.*);

// File: tb/line_route_chan_tb_top.sv
`timescale 1ns/1ps
module line_route_chan_tb_top;
  localparam int HANG = 5;
  localparam int NVEC = 12;
  // {cfg[7:0], rts, dtr, tx_clk, aux_in, txen, rxen, aux_out, rclk, cts}
  localparam logic [16:0] VEC [NVEC] = '{
    17'b00000000_1001_11101,
    17'b00000001_0010_01010,
    17'b00100001_0101_10001,
    17'b00100010_0110_01010,
    17'b00000100_0010_11110,
    17'b00001000_1000_11101,
    17'b00001000_0011_11010,
    17'b00011100_0010_11010,
    17'b00011100_1001_11101,
    17'b11000000_0010_11010,
    17'b00111111_1100_01001,
    17'b00101010_1010_10101
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] route_cfg = 0;
  logic rts = 0, dtr = 0, tx_clk = 0, aux_in = 0, tx_busy = 0;
  logic txen, rxen, aux_out, rclk, cts;
  logic [7:0] route_q;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_route_chan #(.BIT_CYCLES(HANG)) dut_i (
    .clk(clk), .rst_n(rst_n), .route_cfg(route_cfg), .rts(rts), .dtr(dtr),
    .tx_clk(tx_clk), .aux_in(aux_in), .tx_busy(tx_busy), .txen(txen),
    .rxen(rxen), .aux_out(aux_out), .rclk(rclk), .cts(cts), .route_q(route_q)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [4:0] model(input logic [7:0] c, input logic r, d, t, a);
    logic te, re, ao, rc, ct;
    case (c[1:0])
      2'b00: te = 1'b1;
      2'b01: te = d;
      2'b10: te = r;
      default: te = 1'b0;
    endcase
    re = c[5] ? !te : 1'b1;
    if (c[4]) begin ao = a; rc = t; ct = r; end
    else begin
      ao = c[2] ? t : r;
      rc = c[3] ? a : t;
      ct = c[3] ? r : a;
    end
    return {te, re, ao, rc, ct};
  endfunction

  task automatic compare(input logic [7:0] c, input logic [4:0] e);
    chk("R3 txen", {7'd0, txen}, {7'd0, e[4]});
    chk("R8 rxen", {7'd0, rxen}, {7'd0, e[3]});
    chk(c[4] ? "R7 aux_out" : "R5 aux_out", {7'd0, aux_out}, {7'd0, e[2]});
    chk(c[4] ? "R7 rclk" : "R6 rclk", {7'd0, rclk}, {7'd0, e[1]});
    chk(c[4] ? "R7 cts" : "R6 cts", {7'd0, cts}, {7'd0, e[0]});
    chk("R9 route_q", route_q, {2'b00, c[5:0]});
  endtask

  task automatic apply(input logic [7:0] c, input logic [3:0] ins);
    @(negedge clk);
    route_cfg = c;
    {rts, dtr, tx_clk, aux_in} = ins;
    @(negedge clk);
  endtask

  initial begin
    route_cfg = 8'h3F;
    repeat (3) @(negedge clk);
    chk("R1 txen in reset", {7'd0, txen}, 8'd1);
    chk("R1 rxen in reset", {7'd0, rxen}, 8'd1);
    chk("R1 route_q in reset", route_q, 8'h00);
    route_cfg = 8'h00;
    rst_n = 1;
    @(negedge clk);
    chk("R1 txen after reset", {7'd0, txen}, 8'd1);
    chk("R1 rxen after reset", {7'd0, rxen}, 8'd1);
    chk("R1 route_q after reset", route_q, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][16:9], VEC[i][8:5]);
      compare(VEC[i][16:9], VEC[i][4:0]);
    end

    for (int c = 0; c < 64; c++)
      for (int v = 0; v < 16; v++) begin
        apply(8'(c), 4'(v));
        compare(8'(c), model(8'(c), v[3], v[2], v[1], v[0]));
      end

    // R9: upper bits alone change nothing
    apply(8'h08, 4'b1001);
    apply(8'hC8, 4'b1001);
    compare(8'h08, model(8'h08, 1'b1, 1'b0, 1'b0, 1'b1));

    // R2: decode waits for the edge
    apply(8'h00, 4'b0010);
    @(negedge clk);
    route_cfg = 8'h04;
    #1 chk("R2 aux_out before edge", {7'd0, aux_out}, 8'd0);
    @(negedge clk);
    chk("R2 aux_out after edge", {7'd0, aux_out}, 8'd1);

    // R3: registered DTR follow
    apply(8'h01, 4'b0000);
    dtr = 1;
    #1 chk("R3 txen holds old dtr", {7'd0, txen}, 8'd0);
    @(negedge clk);
    chk("R3 txen takes new dtr", {7'd0, txen}, 8'd1);

    // R4: auto-toggle with inverted receiver
    apply(8'h23, 4'b0000);
    chk("R4 txen idle", {7'd0, txen}, 8'd0);
    chk("R8 rxen idle", {7'd0, rxen}, 8'd1);
    tx_busy = 1;
    #1 chk("R4 txen same cycle as busy", {7'd0, txen}, 8'd1);
    chk("R8 rxen off while sending", {7'd0, rxen}, 8'd0);
    repeat (7) @(negedge clk);
    tx_busy = 0;
    #1;
    for (int k = 0; k < HANG; k++) begin
      chk("R4 hangover held", {7'd0, txen}, 8'd1);
      @(negedge clk);
    end
    chk("R4 hangover ended", {7'd0, txen}, 8'd0);
    chk("R8 rxen back on", {7'd0, rxen}, 8'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule